// File: doc/BRIEF.md
# Cache-Line Access Ordering Logger

This debug-only block sits next to a level-one cache controller and records the order in which memory accesses touch each tracked line. It is used during post-silicon bring-up. Every tracked line carries a store counter and an access vector with one sequence-ID field per core. A store by any core bumps the line's counter and writes the new value into that core's field. Each load or store issued by the local core appends a snapshot to an activity log, in program order. The snapshot holds the address tag and the line's vector after the access.

When the log region is full, logging stops and a check request is raised. A later checking phase drains the log through a read port, then pulses a clear to start a new window. A global enable switches the whole block off. While it is off, nothing in it changes.

Top module: `line_order_logger`

## Requirements
- R1: While reset is held and after its release, `chk_req`, `cnt_ovf` and `rd_resp_valid` are low. Every line of the vector table is cleared. The log write pointer is zero, so the first logged access lands in log slot 0.
- R2: A store to a line works in two steps. First the line's counter goes up by one. Then the new count is written into the storing core's field. A local store uses field `LOCAL_ID`, and a remote store (`rmt_valid`) uses field `rmt_core`. For example, with `LOCAL_ID`=0, the sequence local store, core 1 store, local store leaves field 0 at 3 and field 1 at 2.
- R3: A local load changes neither the counter nor any field. It logs the vector as it stands.
- R4: While logging is active, each local access (`loc_valid`) writes one entry to the next log slot, in issue order. The entry is `{loc_tag, vector after the access}`. Remote stores update the table but write no entry.
- R5: A line's slot is selected by the low log2(`LINES`) bits of the tag. An access whose tag differs from the tag the slot holds, or one that reaches a never-used slot, first clears that slot's counter and all its fields, and only then applies itself.
- R6: When a remote store and a local access arrive in the same cycle, the remote store is applied first. If both target the same line, the local access sees, and logs, the vector that already includes the remote store.
- R7: After `LOG_DEPTH` entries have been written, `chk_req` is high from the next cycle and stays high until a clear. While it is high, accesses write no log entry and leave the vector table unchanged.
- R8: While `log_en` is low, accesses write no log entry and leave the vector table unchanged.
- R9: `rd_ready` is high exactly when `log_en` is low or `chk_req` is high. A cycle with `rd_valid` and `rd_ready` both high makes `rd_resp_valid` high in the next cycle, carrying the entry at slot `rd_idx`. Any other cycle gives low `rd_resp_valid` in the next cycle. Core c's field sits at `rd_resp_vec[c*SEQ_W +: SEQ_W]`.
- R10: A `clr_log` pulse resets the log pointer to zero and makes `chk_req` and `cnt_ovf` low in the next cycle. An access presented in the same cycle as the pulse is ignored. The vector table is kept.
- R11: A store to a line whose counter already holds 2^`SEQ_W`-1 leaves the counter at that value and writes that value into the storing core's field. It also sets `cnt_ovf`, which stays set until `clr_log`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| log_en | input | 1 | Global enable of the logger |
| clr_log | input | 1 | Pulse: empty the log and resume logging |
| loc_valid | input | 1 | Local core access this cycle |
| loc_store | input | 1 | Local access is a store (1) or a load (0) |
| loc_tag | input | TAG_W | Line tag of the local access |
| rmt_valid | input | 1 | Store by another core observed this cycle |
| rmt_core | input | CID_W | Core number of the remote store |
| rmt_tag | input | TAG_W | Line tag of the remote store |
| rd_valid | input | 1 | Log read request |
| rd_idx | input | PTR_W | Log slot to read |
| rd_ready | output | 1 | Read requests are accepted |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_tag | output | TAG_W | Tag of the read entry |
| rd_resp_vec | output | NUM_CORES*SEQ_W | Access vector of the read entry |
| chk_req | output | 1 | Log full, checking phase requested |
| cnt_ovf | output | 1 | Sticky counter saturation flag |

## Verification
The bench drives one directed cycle with a local store and a remote store to the same line. If the design applied them in the wrong order, the logged vector would show the local store with the lower sequence ID. A tag that aliases a tracked line's slot must come back as an all-zero vector; a design that skipped the clear would leak the previous line's counts. A line is pushed past its counter limit: a wrapping counter would log zero instead of the maximum and never raise the flag. The log is then filled, and further traffic is sent before the log is cleared. A design that kept logging or kept updating its table while full would show entries overwritten, or vectors that differ once logging resumes.

// File: rtl/lol_pkg.sv
package lol_pkg;

  // Saturating successor used by the per-line store counter.
  function automatic logic [31:0] sat_inc(input logic [31:0] cur, input logic [31:0] lim);
    return (cur >= lim) ? lim : cur + 32'd1;
  endfunction

  // Width of a core-number field, kept at least one bit wide.
  function automatic int core_id_width(input int cores);
    return (cores > 1) ? $clog2(cores) : 1;
  endfunction

endpackage

// File: rtl/lol_vec_table.sv
module lol_vec_table
  import lol_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LOCAL_ID  = 0,
  parameter int LINES     = 8,
  parameter int TAG_W     = 8,
  parameter int SEQ_W     = 6,
  localparam int CID_W    = core_id_width(NUM_CORES),
  localparam int VEC_W    = NUM_CORES * SEQ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             loc_valid,
  input  logic             loc_store,
  input  logic [TAG_W-1:0] loc_tag,
  input  logic             rmt_valid,
  input  logic [CID_W-1:0] rmt_core,
  input  logic [TAG_W-1:0] rmt_tag,
  output logic [VEC_W-1:0] snap_vec,
  output logic             ovf_evt
);

  localparam int IDX_W = $clog2(LINES);
  localparam logic [31:0] CNT_MAX = (32'd1 << SEQ_W) - 32'd1;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [SEQ_W-1:0] cnt;
    logic [VEC_W-1:0] vec;
  } line_t;

  // Allocate on tag mismatch, then apply a store if there is one.
  function automatic line_t apply_acc(input line_t cur, input logic [TAG_W-1:0] t,
                                      input logic st, input logic [CID_W-1:0] c);
    line_t o;
    o = cur;
    if (!o.vld || o.tag != t) begin
      o.vld = 1'b1;
      o.tag = t;
      o.cnt = '0;
      o.vec = '0;
    end
    if (st) begin
      o.cnt = SEQ_W'(sat_inc(32'(o.cnt), CNT_MAX));
      o.vec[int'(c)*SEQ_W +: SEQ_W] = o.cnt;
    end
    return o;
  endfunction

  // A store that finds its own line already at the counter limit.
  function automatic logic hits_limit(input line_t cur, input logic [TAG_W-1:0] t,
                                      input logic st);
    return st && cur.vld && (cur.tag == t) && (32'(cur.cnt) == CNT_MAX);
  endfunction

  line_t            tbl_q [LINES];
  logic [IDX_W-1:0] r_idx, l_idx;
  logic             r_act, l_act, same_line;
  line_t            r_img, l_base, l_img;

  always_comb begin
    r_idx     = rmt_tag[IDX_W-1:0];
    l_idx     = loc_tag[IDX_W-1:0];
    r_act     = go & rmt_valid;
    l_act     = go & loc_valid;
    r_img     = apply_acc(tbl_q[r_idx], rmt_tag, 1'b1, rmt_core);
    same_line = r_act && (r_idx == l_idx);
    l_base    = same_line ? r_img : tbl_q[l_idx];
    l_img     = apply_acc(l_base, loc_tag, loc_store, CID_W'(LOCAL_ID));
    snap_vec  = l_img.vec;
    ovf_evt   = (r_act && hits_limit(tbl_q[r_idx], rmt_tag, 1'b1)) ||
                (l_act && hits_limit(l_base, loc_tag, loc_store));
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic l_sel, r_sel;
    assign l_sel = l_act && (l_idx == IDX_W'(g));
    assign r_sel = r_act && (r_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tbl_q[g] <= '0;
      else if (l_sel) tbl_q[g] <= l_img;
      else if (r_sel) tbl_q[g] <= r_img;
    end
  end

endmodule

// File: rtl/lol_log_store.sv
module lol_log_store #(
  parameter int DEPTH   = 64,
  parameter int ENTRY_W = 32,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic               full,
  output logic [PTR_W:0]     wr_ptr,
  input  logic               rd_fire,
  input  logic [PTR_W-1:0]   rd_idx,
  output logic               rd_vld,
  output logic [ENTRY_W-1:0] rd_data
);

  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [PTR_W:0]     ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (clr)   ptr_q <= '0;
    else if (wr_en) ptr_q <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[ptr_q[PTR_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= rd_fire;
  end

  always_ff @(posedge clk) begin
    if (rd_fire) rd_data <= mem_q[rd_idx];
  end

  assign full   = (ptr_q == (PTR_W+1)'(DEPTH));
  assign wr_ptr = ptr_q;

endmodule

// File: rtl/line_order_logger.sv
module line_order_logger
  import lol_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LOCAL_ID  = 0,
  parameter int LINES     = 8,
  parameter int TAG_W     = 8,
  parameter int SEQ_W     = 6,
  parameter int LOG_DEPTH = 64,
  localparam int CID_W    = core_id_width(NUM_CORES),
  localparam int VEC_W    = NUM_CORES * SEQ_W,
  localparam int PTR_W    = $clog2(LOG_DEPTH),
  localparam int ENTRY_W  = TAG_W + VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             log_en,
  input  logic             clr_log,
  input  logic             loc_valid,
  input  logic             loc_store,
  input  logic [TAG_W-1:0] loc_tag,
  input  logic             rmt_valid,
  input  logic [CID_W-1:0] rmt_core,
  input  logic [TAG_W-1:0] rmt_tag,
  input  logic             rd_valid,
  input  logic [PTR_W-1:0] rd_idx,
  output logic             rd_ready,
  output logic             rd_resp_valid,
  output logic [TAG_W-1:0] rd_resp_tag,
  output logic [VEC_W-1:0] rd_resp_vec,
  output logic             chk_req,
  output logic             cnt_ovf
);

  logic               log_full;
  logic               log_active;
  logic               log_wr;
  logic               rd_fire;
  logic               ovf_evt;
  logic [VEC_W-1:0]   snap_vec;
  logic [PTR_W:0]     wr_ptr;
  logic [ENTRY_W-1:0] rd_entry;

  assign log_active = log_en & ~log_full & ~clr_log;
  assign log_wr     = log_active & loc_valid;
  assign rd_ready   = ~log_en | log_full;
  assign rd_fire    = rd_valid & rd_ready;

  lol_vec_table #(
    .NUM_CORES(NUM_CORES), .LOCAL_ID(LOCAL_ID), .LINES(LINES),
    .TAG_W(TAG_W), .SEQ_W(SEQ_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .go(log_active),
    .loc_valid(loc_valid), .loc_store(loc_store), .loc_tag(loc_tag),
    .rmt_valid(rmt_valid), .rmt_core(rmt_core), .rmt_tag(rmt_tag),
    .snap_vec(snap_vec), .ovf_evt(ovf_evt)
  );

  lol_log_store #(.DEPTH(LOG_DEPTH), .ENTRY_W(ENTRY_W)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(clr_log), .wr_en(log_wr),
    .wr_data({loc_tag, snap_vec}), .full(log_full), .wr_ptr(wr_ptr),
    .rd_fire(rd_fire), .rd_idx(rd_idx), .rd_vld(rd_resp_valid), .rd_data(rd_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_ovf <= 1'b0;
    else if (clr_log)               cnt_ovf <= 1'b0;
    else if (log_active && ovf_evt) cnt_ovf <= 1'b1;
  end

  assign chk_req     = log_full;
  assign rd_resp_tag = rd_entry[ENTRY_W-1 -: TAG_W];
  assign rd_resp_vec = rd_entry[VEC_W-1:0];

endmodule

// File: rtl/lol_checker.sv
module lol_checker #(
  parameter int PTR_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           log_en,
  input logic           clr_log,
  input logic           rd_valid,
  input logic           rd_ready,
  input logic           rd_resp_valid,
  input logic           chk_req,
  input logic           cnt_ovf,
  input logic           log_wr,
  input logic [PTR_W:0] wr_ptr
);

  // R9: accepted request gives a response one cycle later
  a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rd_resp_valid);

  // R9: no response without an accepted request
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> !rd_resp_valid);

  // R10: clear drops the request and the overflow flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_log |=> (!chk_req && !cnt_ovf));

  // R7: the check request holds until a clear
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !clr_log) |=> chk_req);

  // R7: nothing is written while full
  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> !log_wr);

  // R8: nothing is written while disabled
  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !log_en |-> !log_wr);

  // R11: overflow flag is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ovf && !clr_log) |=> cnt_ovf);

  // R4: each write advances the pointer by one slot
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (log_wr && !clr_log) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

  // R4: pointer is still without a write or clear
  a_r4_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!log_wr && !clr_log) |=> $stable(wr_ptr));

endmodule

bind line_order_logger lol_checker #(.PTR_W(PTR_W)) u_lol_chk (
  .clk(clk), .rst_n(rst_n), .log_en(log_en), .clr_log(clr_log),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid),
  .chk_req(chk_req), .cnt_ovf(cnt_ovf), .log_wr(log_wr), .wr_ptr(wr_ptr)
);

// File: tb/line_order_logger_tb_top.sv
`timescale 1ns/1ps
module line_order_logger_tb_top;

  localparam int NC = 4, LOC = 0, NL = 8, TW = 8, SW = 6, DEPTH = 64;
  localparam int MAXC = (1 << SW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic log_en = 1'b0, clr_log = 1'b0;
  logic loc_valid = 1'b0, loc_store = 1'b0, rmt_valid = 1'b0, rd_valid = 1'b0;
  logic [TW-1:0] loc_tag = '0, rmt_tag = '0;
  logic [1:0] rmt_core = '0;
  logic [5:0] rd_idx = '0;
  logic rd_ready, rd_resp_valid, chk_req, cnt_ovf;
  logic [TW-1:0] rd_resp_tag;
  logic [NC*SW-1:0] rd_resp_vec;

  always #2 clk = ~clk;

  line_order_logger dut_i (
    .clk(clk), .rst_n(rst_n), .log_en(log_en), .clr_log(clr_log),
    .loc_valid(loc_valid), .loc_store(loc_store), .loc_tag(loc_tag),
    .rmt_valid(rmt_valid), .rmt_core(rmt_core), .rmt_tag(rmt_tag),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_ready(rd_ready),
    .rd_resp_valid(rd_resp_valid), .rd_resp_tag(rd_resp_tag), .rd_resp_vec(rd_resp_vec),
    .chk_req(chk_req), .cnt_ovf(cnt_ovf)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model
  int m_v[NL], m_tag[NL], m_cnt[NL], m_f[NL][NC];
  int lg_tag[DEPTH], lg_f[DEPTH][NC];
  int mptr = 0;
  bit movf = 0;
  int last_f[NC];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic m_touch(input int t, input bit st, input int c);
    int i = t % NL;
    if (m_v[i] == 0 || m_tag[i] != t) begin
      m_v[i] = 1; m_tag[i] = t; m_cnt[i] = 0;
      for (int k = 0; k < NC; k++) m_f[i][k] = 0;
    end
    if (st) begin
      if (m_cnt[i] == MAXC) movf = 1;
      else m_cnt[i] = m_cnt[i] + 1;
      m_f[i][c] = m_cnt[i];
    end
  endtask

  task automatic m_step(input bit lv, input bit ls, input int lt, input bit rv, input int rc, input int rt);
    if (clr_log) begin mptr = 0; movf = 0; return; end
    if (!log_en || mptr == DEPTH) return;
    if (rv) m_touch(rt, 1, rc);
    if (lv) begin
      m_touch(lt, ls, LOC);
      lg_tag[mptr] = lt;
      for (int k = 0; k < NC; k++) lg_f[mptr][k] = m_f[lt % NL][k];
      mptr++;
    end
  endtask

  task automatic step(input bit lv, input bit ls, input int lt, input bit rv, input int rc, input int rt);
    loc_valid = lv; loc_store = ls; loc_tag = TW'(lt);
    rmt_valid = rv; rmt_core = 2'(rc); rmt_tag = TW'(rt);
    m_step(lv, ls, lt, rv, rc, rt);
    @(posedge clk); @(negedge clk);
    loc_valid = 0; rmt_valid = 0; clr_log = 0;
    chk(chk_req == (mptr == DEPTH), "R7", "chk_req", int'(chk_req), int'(mptr == DEPTH));
    chk(cnt_ovf == movf, "R11", "cnt_ovf", int'(cnt_ovf), int'(movf));
    chk(!rd_resp_valid, "R9", "idle rd_resp_valid", int'(rd_resp_valid), 0);
  endtask

  task automatic rd_chk(input int idx);
    chk(rd_ready == 1'b1, "R9", "rd_ready", int'(rd_ready), 1);
    rd_valid = 1; rd_idx = 6'(idx);
    @(posedge clk); @(negedge clk);
    rd_valid = 0;
    chk(rd_resp_valid == 1'b1, "R9", "rd_resp_valid", int'(rd_resp_valid), 1);
    chk(int'(rd_resp_tag) == lg_tag[idx], "R4", "entry tag", int'(rd_resp_tag), lg_tag[idx]);
    for (int k = 0; k < NC; k++) begin
      last_f[k] = int'(rd_resp_vec[k*SW +: SW]);
      chk(last_f[k] == lg_f[idx][k], "R4", "entry field", last_f[k], lg_f[idx][k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NL; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_cnt[i] = 0;
      for (int k = 0; k < NC; k++) m_f[i][k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!chk_req && !cnt_ovf && !rd_resp_valid, "R1", "outputs in reset", int'(chk_req) + int'(cnt_ovf), 0);
    rst_n = 1; log_en = 1;
    @(negedge clk);
    chk(!chk_req && !cnt_ovf, "R1", "outputs after reset", int'(chk_req) + int'(cnt_ovf), 0);
    chk(rd_ready == 1'b0, "R9", "rd_ready while logging", int'(rd_ready), 0);

    // directed sequence, entries 0..7
    step(1, 1, 'h11, 0, 0, 0);           // e0 local store A
    step(0, 0, 0, 1, 1, 'h11);           // remote core1 store A
    step(1, 1, 'h11, 0, 0, 0);           // e1 local store A -> c0=3 c1=2
    step(1, 0, 'h11, 0, 0, 0);           // e2 load A
    step(1, 0, 'h22, 1, 2, 'h22);        // e3 load B with remote store B same cycle
    step(1, 1, 'h11, 1, 3, 'h11);        // e4 store A, remote core3 store A
    step(1, 0, 'h19, 0, 0, 0);           // e5 alias of A slot
    step(1, 0, 'h11, 0, 0, 0);           // e6 A reallocated
    log_en = 0;
    step(1, 1, 'h22, 1, 1, 'h22);        // ignored while disabled
    log_en = 1;
    step(1, 0, 'h22, 0, 0, 0);           // e7 load B
    log_en = 0;
    @(negedge clk);
    for (int e = 0; e < 8; e++) begin
      rd_chk(e);
      if (e == 1) begin
        chk(last_f[0] == 3, "R2", "local field", last_f[0], 3);
        chk(last_f[1] == 2, "R2", "remote field", last_f[1], 2);
      end
      if (e == 2) chk(last_f[0] == 3 && last_f[1] == 2, "R3", "load keeps vector", last_f[0], 3);
      if (e == 3) chk(last_f[2] == 1, "R6", "remote first", last_f[2], 1);
      if (e == 4) begin
        chk(last_f[3] == 4, "R6", "remote store ordered first", last_f[3], 4);
        chk(last_f[0] == 5, "R6", "local store ordered second", last_f[0], 5);
      end
      if (e == 5 || e == 6) chk(last_f[0] + last_f[1] + last_f[2] + last_f[3] == 0, "R5", "cleared on alloc", last_f[0], 0);
      if (e == 7) chk(last_f[1] == 0 && last_f[0] == 0 && last_f[2] == 1, "R8", "disabled no change", last_f[1], 0);
    end

    // clear with a concurrent access that must be ignored
    log_en = 1; clr_log = 1;
    step(1, 1, 'h11, 0, 0, 0);
    chk(!chk_req, "R10", "chk_req after clear", int'(chk_req), 0);
    step(1, 0, 'h11, 0, 0, 0);           // e0 after clear, A still zero

    // saturation of line C
    for (int n = 0; n < MAXC; n++) step(0, 0, 0, 1, 3, 'h33);
    chk(cnt_ovf == 1'b0, "R11", "no flag at limit", int'(cnt_ovf), 0);
    step(0, 0, 0, 1, 3, 'h33);
    chk(cnt_ovf == 1'b1, "R11", "flag past limit", int'(cnt_ovf), 1);
    step(1, 0, 'h33, 0, 0, 0);           // e1

    // random fill to full, then extra traffic while full
    while (mptr < DEPTH) begin
      log_en = ($urandom_range(0, 7) != 0);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 23),
           $urandom_range(0, 1) == 1, $urandom_range(0, 3), $urandom_range(0, 23));
    end
    log_en = 1;
    for (int n = 0; n < 6; n++)
      step(1, 1, $urandom_range(0, 23), 1, $urandom_range(0, 3), $urandom_range(0, 23));
    chk(chk_req == 1'b1, "R7", "full request", int'(chk_req), 1);
    for (int e = 0; e < DEPTH; e++) begin
      rd_chk(e);
      if (e == 0) chk(last_f[0] == 0, "R10", "access with clear ignored", last_f[0], 0);
      if (e == 1) chk(last_f[3] == MAXC, "R11", "saturated field", last_f[3], MAXC);
    end

    // clear, then probe table frozen while full
    clr_log = 1;
    step(0, 0, 0, 0, 0, 0);
    chk(!chk_req && !cnt_ovf, "R10", "clear drops flags", int'(chk_req) + int'(cnt_ovf), 0);
    for (int n = 0; n < 8; n++) step(1, 0, n + 8 * $urandom_range(0, 2), 0, 0, 0);
    log_en = 0;
    @(negedge clk);
    for (int e = 0; e < 8; e++) rd_chk(e);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule